// File: doc/BRIEF.md
# Receive Flow-Control RTS Generator

This block produces an active-low request-to-send line for a serial receiver. It watches the fill count of a 128-entry receive FIFO and holds the far end off once the count climbs to a programmable trigger plus a hysteresis band. It releases the far end only when the count drains to the trigger minus that band. The band width comes from a fixed, non-linear 16-entry table. A 4-bit selector indexes the table: its upper two bits come from an extended configuration field and its lower two bits from a control field.

The block also holds a small register set around the comparator. A write-only trigger register is steered by a destination bit into either the receive or the transmit trigger, and both values are kept. A read port returns either a scratch byte or a FIFO level view, and a 2-bit mode chooses which count that view reports. When automatic flow control is off, the line simply follows a software request bit. The FIFO storage, the serial engines, the baud generator and the interrupts all sit outside this block.

Top module: `rxfc_rts_gen`

## Requirements
- R1: After synchronous reset, `rts_n` is 1, the scratch byte reads 0, and both triggers hold `RST_TRIG` (default 64).
- R2: The band in characters for selector {`hys_ext`,`hys_ctl`} is: 0→0, 1→4, 2→6, 3→8, 4→8, 5→16, 6→24, 7→32, 8→40, 9→44, 10→48, 11→52, 12→12, 13→20, 14→28, 15→36.
- R3: With `afc_en`=1, `rts_n` becomes 1 one clock after a cycle in which `rx_level` ≥ upper = min(trigger+band, 128).
- R4: Once high, `rts_n` stays high until a cycle in which `rx_level` ≤ lower = max(trigger−band, 0) and `rx_level` < upper. It is 0 one clock later.
- R5: With a band of 0, `rts_n` goes high at `rx_level` ≥ trigger and low again at `rx_level` < trigger.
- R6: The upper threshold saturates at 128 and the lower threshold at 0.
- R7: With `afc_en`=0, `rts_n` equals the inverse of `sw_rts` one clock later. The hold state is cleared, so flow control starts from the asserted (low) state when it is enabled again.
- R8: A cycle with `trg_we`=1 stores `trg_wdata` into the receive trigger when `trg_dst_tx`=0 and into the transmit trigger when `trg_dst_tx`=1. The other trigger is unchanged. The transmit trigger appears on `tx_trig`. A new value takes effect from the next clock.
- R9: With `lvl_view`=1, `rd_data` reports the receive count for `lvl_mode`=0 and the transmit count for `lvl_mode`=1. For `lvl_mode`=2 or 3 it reports their sum, saturated at 255.
- R10: With `lvl_view`=0, `rd_data` returns the scratch byte. A cycle with `spr_we`=1 stores `spr_wdata` into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | 8 | Receive FIFO fill count, 0..128 |
| tx_level | input | 8 | Transmit FIFO fill count, 0..128 |
| hys_ext | input | 2 | Upper two bits of the band selector |
| hys_ctl | input | 2 | Lower two bits of the band selector |
| trg_we | input | 1 | Trigger register write strobe |
| trg_dst_tx | input | 1 | Write destination: 0 receive trigger, 1 transmit trigger |
| trg_wdata | input | 8 | Trigger write data |
| spr_we | input | 1 | Scratch byte write strobe |
| spr_wdata | input | 8 | Scratch byte write data |
| lvl_view | input | 1 | 1 selects the level view on the read port, 0 the scratch byte |
| lvl_mode | input | 2 | Level view source: 0 receive, 1 transmit, 2/3 saturated sum |
| rd_data | output | 8 | Read port data |
| tx_trig | output | 8 | Stored transmit trigger level |
| afc_en | input | 1 | Automatic flow control enable |
| sw_rts | input | 1 | Software request, active high, used when `afc_en`=0 |
| rts_n | output | 1 | Registered active-low request-to-send |

## Verification
A stale or wrong hold state shows directly on `rts_n` one clock after the level sample that should have flipped it. The sweeps make every band show up there. They ramp the level up and down through each selector value and compare each cycle, so a wrong table entry or a missed crossing appears on the edge where it occurs. A hold state that survives a disable period is caught by re-enabling with the level inside the band. A misrouted trigger write changes the edge where `rts_n` rises, from the next clock on.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    parameter int DATA_W = 8;
    parameter int DEPTH  = 128;
    parameter int HYS_W  = 6;

    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int EXT_W = ((LVL_W > DATA_W) ? LVL_W : DATA_W) + 1;

    typedef logic [3:0] hys_sel_t;

    typedef enum logic [1:0] {
        LM_RX   = 2'b00,
        LM_TX   = 2'b01,
        LM_SUMA = 2'b10,
        LM_SUMB = 2'b11
    } lvl_mode_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } rts_state_e;

    typedef struct packed {
        logic              we;
        logic              dst_tx;
        logic [DATA_W-1:0] data;
    } trg_wr_t;

    typedef struct packed {
        logic [EXT_W-1:0] upper;
        logic [EXT_W-1:0] lower;
    } thr_t;

    // Band width in characters for a 4-bit selector {ext, ctl}.
    function automatic logic [HYS_W-1:0] hys_chars(input hys_sel_t s);
        logic [HYS_W-1:0] lo;
        logic [HYS_W-1:0] r;
        lo = HYS_W'(s[1:0]);
        case (s[3:2])
            2'd0:    r = (s[1:0] == 2'd0) ? '0 : (lo << 1) + HYS_W'(2);
            2'd1:    r = HYS_W'(8)  + (lo << 3);
            2'd2:    r = HYS_W'(40) + (lo << 2);
            default: r = HYS_W'(12) + (lo << 3);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxfc_regs.sv
module rxfc_regs
    import rxfc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_TRIG = 8'd64
) (
    input  logic              clk,
    input  logic              rst,
    input  trg_wr_t           trg_wr,
    input  logic              spr_we,
    input  logic [DATA_W-1:0] spr_wdata,
    output logic [DATA_W-1:0] rx_trig,
    output logic [DATA_W-1:0] tx_trig,
    output logic [DATA_W-1:0] scratch
);

    localparam int N_TRIG = 2;

    logic [DATA_W-1:0] trig_q [N_TRIG];

    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
        always_ff @(posedge clk) begin
            if (rst) begin
                trig_q[g] <= RST_TRIG;
            end else if (trg_wr.we && (trg_wr.dst_tx == 1'(g))) begin
                trig_q[g] <= trg_wr.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch <= '0;
        end else if (spr_we) begin
            scratch <= spr_wdata;
        end
    end

    assign rx_trig = trig_q[0];
    assign tx_trig = trig_q[1];

    // R8: a receive-destined write lands in the receive trigger
    p_rx_trig_write_r8: assert property (@(posedge clk) disable iff (rst)
        (trg_wr.we && !trg_wr.dst_tx) |=> (rx_trig == $past(trg_wr.data)));

    // R8: a transmit-destined write leaves the receive trigger alone
    p_tx_write_keeps_rx_r8: assert property (@(posedge clk) disable iff (rst)
        (trg_wr.we && trg_wr.dst_tx) |=> $stable(rx_trig));

endmodule

// File: rtl/rxfc_thresh.sv
module rxfc_thresh
    import rxfc_pkg::*;
(
    input  logic [DATA_W-1:0] trig,
    input  hys_sel_t          sel,
    output thr_t              thr
);

    logic [HYS_W-1:0] band;
    logic [EXT_W-1:0] trig_x;
    logic [EXT_W-1:0] band_x;
    logic [EXT_W-1:0] sum_x;

    always_comb begin
        band   = hys_chars(sel);
        trig_x = EXT_W'(trig);
        band_x = EXT_W'(band);
        sum_x  = trig_x + band_x;
        thr.upper = (sum_x > EXT_W'(DEPTH)) ? EXT_W'(DEPTH) : sum_x;
        thr.lower = (trig_x > band_x) ? (trig_x - band_x) : '0;
    end

endmodule

// File: rtl/rxfc_rts_fsm.sv
module rxfc_rts_fsm
    import rxfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] rx_level,
    input  thr_t             thr,
    input  logic             afc_en,
    input  logic             sw_rts,
    output logic             rts_n
);

    rts_state_e       state;
    rts_state_e       nxt;
    logic [EXT_W-1:0] lvl_x;

    always_comb begin
        lvl_x = EXT_W'(rx_level);
        nxt   = state;
        case (state)
            ST_FLOW: if (lvl_x >= thr.upper) nxt = ST_HOLD;
            ST_HOLD: if ((lvl_x <= thr.lower) && (lvl_x < thr.upper)) nxt = ST_FLOW;
            default: nxt = ST_FLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FLOW;
            rts_n <= 1'b1;
        end else if (!afc_en) begin
            state <= ST_FLOW;
            rts_n <= ~sw_rts;
        end else begin
            state <= nxt;
            rts_n <= (nxt == ST_HOLD);
        end
    end

    // R3: reaching the upper threshold releases RTS on the next clock
    p_deassert_at_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (afc_en && (EXT_W'(rx_level) >= thr.upper)) |=> rts_n);

    // R4: draining to the lower threshold from hold asserts RTS again
    p_reassert_at_lower_r4: assert property (@(posedge clk) disable iff (rst)
        (afc_en && (state == ST_HOLD) && (EXT_W'(rx_level) <= thr.lower)
         && (EXT_W'(rx_level) < thr.upper)) |=> !rts_n);

    // R7: software mode mirrors the request bit one clock later
    p_sw_follow_r7: assert property (@(posedge clk) disable iff (rst)
        !afc_en |=> (rts_n == !$past(sw_rts)));

endmodule

// File: rtl/rxfc_lvl_read.sv
module rxfc_lvl_read
    import rxfc_pkg::*;
(
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  lvl_mode_e         mode,
    input  logic              view,
    input  logic [DATA_W-1:0] scratch,
    output logic [DATA_W-1:0] rd_data
);

    localparam int MAXV = (1 << DATA_W) - 1;

    logic [LVL_W:0]    sum;
    logic [DATA_W-1:0] lvl_val;

    always_comb begin
        sum = {1'b0, rx_level} + {1'b0, tx_level};
        case (mode)
            LM_RX:   lvl_val = DATA_W'(rx_level);
            LM_TX:   lvl_val = DATA_W'(tx_level);
            default: lvl_val = (sum > (LVL_W+1)'(MAXV)) ? DATA_W'(MAXV) : DATA_W'(sum);
        endcase
        rd_data = view ? lvl_val : scratch;
    end

endmodule

// File: rtl/rxfc_rts_gen.sv
module rxfc_rts_gen
    import rxfc_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_TRIG = 8'd64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [1:0]        hys_ext,
    input  logic [1:0]        hys_ctl,
    input  logic              trg_we,
    input  logic              trg_dst_tx,
    input  logic [DATA_W-1:0] trg_wdata,
    input  logic              spr_we,
    input  logic [DATA_W-1:0] spr_wdata,
    input  logic              lvl_view,
    input  logic [1:0]        lvl_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] tx_trig,
    input  logic              afc_en,
    input  logic              sw_rts,
    output logic              rts_n
);

    trg_wr_t           trg_wr;
    thr_t              thr;
    logic [DATA_W-1:0] rx_trig;
    logic [DATA_W-1:0] scratch;
    hys_sel_t          sel;

    assign trg_wr = '{we: trg_we, dst_tx: trg_dst_tx, data: trg_wdata};
    assign sel    = {hys_ext, hys_ctl};

    rxfc_regs #(.RST_TRIG(RST_TRIG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .trg_wr    (trg_wr),
        .spr_we    (spr_we),
        .spr_wdata (spr_wdata),
        .rx_trig   (rx_trig),
        .tx_trig   (tx_trig),
        .scratch   (scratch)
    );

    rxfc_thresh u_thresh (
        .trig (rx_trig),
        .sel  (sel),
        .thr  (thr)
    );

    rxfc_rts_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rx_level (rx_level),
        .thr      (thr),
        .afc_en   (afc_en),
        .sw_rts   (sw_rts),
        .rts_n    (rts_n)
    );

    rxfc_lvl_read u_read (
        .rx_level (rx_level),
        .tx_level (tx_level),
        .mode     (lvl_mode_e'(lvl_mode)),
        .view     (lvl_view),
        .scratch  (scratch),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/tb_rxfc_rts_gen.sv
module tb_rxfc_rts_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] rx_level, tx_level;
    logic [1:0] hys_ext, hys_ctl;
    logic       trg_we, trg_dst_tx;
    logic [7:0] trg_wdata;
    logic       spr_we;
    logic [7:0] spr_wdata;
    logic       lvl_view;
    logic [1:0] lvl_mode;
    logic [7:0] rd_data, tx_trig;
    logic       afc_en, sw_rts;
    logic       rts_n;

    always #4 clk = ~clk;

    rxfc_rts_gen dut (
        .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
        .hys_ext(hys_ext), .hys_ctl(hys_ctl), .trg_we(trg_we),
        .trg_dst_tx(trg_dst_tx), .trg_wdata(trg_wdata), .spr_we(spr_we),
        .spr_wdata(spr_wdata), .lvl_view(lvl_view), .lvl_mode(lvl_mode),
        .rd_data(rd_data), .tx_trig(tx_trig), .afc_en(afc_en),
        .sw_rts(sw_rts), .rts_n(rts_n)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;

    // Pending inputs, applied by tick at the falling edge
    logic       p_afc = 0, p_sw = 0, p_we = 0, p_dst = 0;
    logic [3:0] p_sel = 0;
    logic [7:0] p_data = 0;

    // Reference model state
    int m_rx   = 64;
    int m_tx   = 64;
    bit m_hold = 0;

    function automatic int ref_band(input logic [3:0] s);
        case (s)
            4'd0: return 0;   4'd1: return 4;   4'd2: return 6;   4'd3: return 8;
            4'd4: return 8;   4'd5: return 16;  4'd6: return 24;  4'd7: return 32;
            4'd8: return 40;  4'd9: return 44;  4'd10: return 48; 4'd11: return 52;
            4'd12: return 12; 4'd13: return 20; 4'd14: return 28; default: return 36;
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int lvl, input string tag);
        int  b, up, lo;
        bit  e;
        @(negedge clk);
        rx_level   = 8'(lvl);
        afc_en     = p_afc;
        sw_rts     = p_sw;
        {hys_ext, hys_ctl} = p_sel;
        trg_we     = p_we;
        trg_dst_tx = p_dst;
        trg_wdata  = p_data;
        p_we       = 0;
        b  = ref_band(p_sel);
        up = (m_rx + b > 128) ? 128 : m_rx + b;
        lo = (m_rx > b) ? m_rx - b : 0;
        if (!p_afc) begin
            m_hold = 0;
            e = !p_sw;
        end else begin
            if (m_hold) begin
                if (lvl <= lo && lvl < up) m_hold = 0;
            end else if (lvl >= up) begin
                m_hold = 1;
            end
            e = m_hold;
        end
        q.push_back('{exp: e, tag: tag});
        if (trg_we) begin
            if (trg_dst_tx) m_tx = int'(trg_wdata);
            else            m_rx = int'(trg_wdata);
        end
    endtask

    task automatic write_trig(input bit to_tx, input int val, input int lvl, input string tag);
        p_we = 1; p_dst = to_tx; p_data = 8'(val);
        tick(lvl, tag);
    endtask

    // Monitor: compares rts_n after each edge against the queued expectation
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(int'(rts_n), int'(it.exp), it.tag);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; rx_level = 0; tx_level = 0; hys_ext = 0; hys_ctl = 0;
        trg_we = 0; trg_dst_tx = 0; trg_wdata = 0; spr_we = 0; spr_wdata = 0;
        lvl_view = 0; lvl_mode = 0; afc_en = 0; sw_rts = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        #1;
        check(int'(rts_n), 1, "R1 rts_n after reset");
        check(int'(rd_data), 0, "R1 scratch after reset");
        check(int'(tx_trig), 64, "R1 tx trigger after reset");

        // R1: receive trigger resets to 64 (band 0)
        p_afc = 1; p_sel = 4'd0;
        tick(63, "R1");
        tick(64, "R1");
        tick(0, "R1");

        // R8: route writes
        write_trig(0, 60, 0, "R8");
        write_trig(1, 5, 0, "R8");
        tick(59, "R8 rx trigger unchanged by tx write");
        tick(60, "R8");
        tick(0, "R8");
        #1;
        check(int'(tx_trig), 5, "R8 tx trigger stored");

        // R2/R3/R4: sweep every selector
        for (int s = 0; s < 16; s++) begin
            p_sel = 4'(s);
            for (int l = 0; l <= 128; l++) tick(l, "R2 R3");
            for (int l = 128; l >= 0; l--) tick(l, "R2 R4");
        end

        // R5: zero band
        p_sel = 4'd0;
        tick(59, "R5"); tick(60, "R5"); tick(61, "R5");
        tick(60, "R5"); tick(59, "R5"); tick(60, "R5"); tick(0, "R5");

        // R6: saturation at both ends
        write_trig(0, 120, 0, "R6");
        p_sel = 4'b1000;
        for (int l = 100; l <= 128; l++) tick(l, "R6 upper clamp");
        for (int l = 128; l >= 70; l--) tick(l, "R6");
        tick(0, "R6");
        write_trig(0, 10, 0, "R6");
        p_sel = 4'b1011;
        for (int l = 0; l <= 70; l++) tick(l, "R6");
        for (int l = 70; l >= 0; l--) tick(l, "R6 lower clamp");

        // R7: software mode and hold reset
        write_trig(0, 60, 0, "R7");
        p_sel = 4'b1000;
        tick(110, "R7");
        p_afc = 0; p_sw = 1; tick(110, "R7");
        p_sw = 0; tick(110, "R7");
        p_sw = 1; tick(30, "R7");
        p_afc = 1; tick(30, "R7 hold cleared");
        tick(30, "R7");
        p_afc = 0; p_sw = 0; tick(0, "R7");
        repeat (3) @(negedge clk);

        // R9/R10: read port
        rx_level = 33; tx_level = 77; lvl_view = 1; lvl_mode = 2'd0;
        #1 check(int'(rd_data), 33, "R9 rx view");
        lvl_mode = 2'd1;
        #1 check(int'(rd_data), 77, "R9 tx view");
        lvl_mode = 2'd2;
        #1 check(int'(rd_data), 110, "R9 sum view");
        rx_level = 128; tx_level = 128; lvl_mode = 2'd3;
        #1 check(int'(rd_data), 255, "R9 sum saturates");
        @(negedge clk);
        spr_we = 1; spr_wdata = 8'hA5;
        @(negedge clk);
        spr_we = 0; lvl_view = 0;
        #1 check(int'(rd_data), 165, "R10 scratch readback");
        lvl_view = 1; lvl_mode = 2'd1;
        #1 check(int'(rd_data), 128, "R9 view overrides scratch");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule